// File: doc/BRIEF.md
# Control Endpoint Status Register

This block holds the eight-bit status and control word for the control endpoint of a USB device controller. It sits between a CPU register port and the device-side transaction engine. The engine reports hardware events: a packet arrived from the host, an IN packet went out, a stall handshake was sent, a transfer ended early, or a transfer completed. Software reads the flags and acknowledges them. Some bits are read-only and are cleared only by separate write-only "serviced" strobes. Other bits are write-1-to-set or write-1-to-clear.

The block also raises an endpoint interrupt flag, when interrupts are enabled, each time host data lands and each time a queued IN packet completes. That flag has its own write-1-to-clear strobe. The block also gives the engine a gate that keeps it out of the data stage until software has serviced the received setup packet.

Top module: `ctlEpStatusReg`

## Requirements
- R1: After reset every register bit (0 to 5), the interrupt flag and the stall request read 0, and the data-stage gate reads 1.
- R2: Bit 0 (OUT-ready) is set one cycle after `hwOutRcvd`. Writing bit 0 has no effect on it. Writing 1 to bit 6 clears it. If `hwOutRcvd` and that clear fall in the same cycle, the bit ends up set.
- R3: `dataStageOk` is 0 in every cycle in which bit 0 reads 1, and 1 otherwise.
- R4: Writing 1 to bit 1 (IN-ready) sets it. `hwInSent` while bit 1 is set clears it on the next cycle. That hardware clear wins over a write of 1 to bit 1 in the same cycle. `hwInSent` while bit 1 is clear does nothing.
- R5: With `irqEnable` at 1, `epIrq` rises one cycle after any `hwOutRcvd` and one cycle after a hardware clear of bit 1. With `irqEnable` at 0, neither event sets it.
- R6: `irqClr` clears `epIrq` on the next cycle unless a set event from R5 occurs in the same cycle. In that case the flag stays 1.
- R7: Bit 2 (sent-stall) is set one cycle after `hwStallSent` and cleared by writing 1 to it. The hardware set wins over a same-cycle clear.
- R8: Bit 3 (force-stall) is set by writing 1 to it and drives `stallReq`. It is cleared by `hwStallSent` or `hwXferDone`. A same-cycle software set wins.
- R9: Bit 4 (data-end) is set by writing 1 to it and cleared by `hwXferDone`. A same-cycle software set wins. One write may set bit 4 and service bit 0 together.
- R10: Bit 5 (setup-end) is set by `hwSetupEnd` only when bit 4 was 0 in that cycle. Writing 1 to bit 7 clears it. The hardware set wins over a same-cycle clear.
- R11: Bits 6 and 7 always read 0. Writing 0 to any bit, or writing with `regWrEn` low, changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | CPU write strobe for the register |
| regWrData | input | 8 | CPU write data |
| regRdData | output | 8 | Current register value |
| irqEnable | input | 1 | Endpoint interrupt enable |
| irqClr | input | 1 | Write-1-to-clear strobe for the interrupt flag |
| epIrq | output | 1 | Endpoint interrupt flag |
| hwOutRcvd | input | 1 | Engine: valid packet received from host |
| hwInSent | input | 1 | Engine: IN packet transmitted successfully |
| hwStallSent | input | 1 | Engine: stall handshake sent |
| hwSetupEnd | input | 1 | Engine: control transfer ended early |
| hwXferDone | input | 1 | Engine: control transfer finished |
| dataStageOk | output | 1 | Engine may enter the data stage |
| stallReq | output | 1 | Force a stall handshake |

## Verification
Every flag and the interrupt flag change exactly one clock edge after the write or event that causes them. `regRdData`, `dataStageOk` and `stallReq` follow the register state with no added delay. The bench drives inputs on the falling edge. A behavioural model updates on the rising edge from those same inputs. Every output is compared against the model at the next falling edge, which is one cycle after the stimulus. Collisions between hardware events and software writes come from long biased random phases in which every input is active often.

// File: rtl/ctlEpPkg.sv
package ctlEpPkg;
  localparam int REG_W     = 8;
  localparam int NUM_FLAGS = 6;
  localparam int B_OUT     = 0;
  localparam int B_IN      = 1;
  localparam int B_SST     = 2;
  localparam int B_FST     = 3;
  localparam int B_DE      = 4;
  localparam int B_SE      = 5;
  localparam int B_SVC_OUT = 6;
  localparam int B_SVC_SE  = 7;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setVec;
    logic [NUM_FLAGS-1:0] clrVec;
    logic                 setIrq;
    logic                 clrIrq;
  } epStrobes_t;
endpackage

// File: rtl/ctlEpControl.sv
module ctlEpControl
  import ctlEpPkg::*;
(
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  input  logic                 irqEnable,
  input  logic                 irqClr,
  input  logic                 hwOutRcvd,
  input  logic                 hwInSent,
  input  logic                 hwStallSent,
  input  logic                 hwSetupEnd,
  input  logic                 hwXferDone,
  input  logic [NUM_FLAGS-1:0] flagsQ,
  output epStrobes_t           strobes
);
  logic [REG_W-1:0] wrOnes;
  logic             inDone;

  always_comb begin
    wrOnes = regWrEn ? regWrData : '0;
    inDone = hwInSent & flagsQ[B_IN];

    strobes = '0;
    // OUT-ready: hardware set, serviced strobe clears
    strobes.setVec[B_OUT] = hwOutRcvd;
    strobes.clrVec[B_OUT] = wrOnes[B_SVC_OUT];
    // IN-ready: software set, completion clear (clear wins)
    strobes.setVec[B_IN]  = wrOnes[B_IN] & ~inDone;
    strobes.clrVec[B_IN]  = inDone;
    // sent-stall: hardware set, write-1-to-clear
    strobes.setVec[B_SST] = hwStallSent;
    strobes.clrVec[B_SST] = wrOnes[B_SST];
    // force-stall: software set, engine clears
    strobes.setVec[B_FST] = wrOnes[B_FST];
    strobes.clrVec[B_FST] = hwStallSent | hwXferDone;
    // data-end: software set, engine clears on completion
    strobes.setVec[B_DE]  = wrOnes[B_DE];
    strobes.clrVec[B_DE]  = hwXferDone;
    // setup-end: early end only counts before data-end
    strobes.setVec[B_SE]  = hwSetupEnd & ~flagsQ[B_DE];
    strobes.clrVec[B_SE]  = wrOnes[B_SVC_SE];
    // interrupt flag
    strobes.setIrq = irqEnable & (hwOutRcvd | inDone);
    strobes.clrIrq = irqClr;
  end
endmodule

// File: rtl/ctlEpDatapath.sv
module ctlEpDatapath
  import ctlEpPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  epStrobes_t           strobes,
  output logic [NUM_FLAGS-1:0] flagsQ,
  output logic                 irqQ
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flagsQ[i] <= 1'b0;
      else       flagsQ[i] <= strobes.setVec[i] | (flagsQ[i] & ~strobes.clrVec[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= strobes.setIrq | (irqQ & ~strobes.clrIrq);
  end
endmodule

// File: rtl/ctlEpStatusReg.sv
module ctlEpStatusReg
  import ctlEpPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             irqEnable,
  input  logic             irqClr,
  output logic             epIrq,
  input  logic             hwOutRcvd,
  input  logic             hwInSent,
  input  logic             hwStallSent,
  input  logic             hwSetupEnd,
  input  logic             hwXferDone,
  output logic             dataStageOk,
  output logic             stallReq
);
  epStrobes_t           strobes;
  logic [NUM_FLAGS-1:0] flagsQ;

  ctlEpControl u_ctl (
    .regWrEn(regWrEn), .regWrData(regWrData),
    .irqEnable(irqEnable), .irqClr(irqClr),
    .hwOutRcvd(hwOutRcvd), .hwInSent(hwInSent),
    .hwStallSent(hwStallSent), .hwSetupEnd(hwSetupEnd),
    .hwXferDone(hwXferDone), .flagsQ(flagsQ), .strobes(strobes)
  );

  ctlEpDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .flagsQ(flagsQ), .irqQ(epIrq)
  );

  assign regRdData   = {{(REG_W-NUM_FLAGS){1'b0}}, flagsQ};
  assign dataStageOk = ~flagsQ[B_OUT];
  assign stallReq    = flagsQ[B_FST];
endmodule

// File: rtl/ctlEpStatusReg_chk.sv
module ctlEpStatusReg_chk
  import ctlEpPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             irqEnable,
  input logic             irqClr,
  input logic             epIrq,
  input logic             hwOutRcvd,
  input logic             hwInSent,
  input logic             hwStallSent,
  input logic             hwSetupEnd,
  input logic             hwXferDone
);
  AST_OUT_SET: assert property (@(posedge clk) disable iff (!rstN)
    hwOutRcvd |=> regRdData[B_OUT]); // R2
  AST_IN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (hwInSent && regRdData[B_IN]) |=> !regRdData[B_IN]); // R4
  AST_IRQ_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable && hwOutRcvd) |=> epIrq); // R5
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !irqEnable) |=> !epIrq); // R6
  AST_SST_SET: assert property (@(posedge clk) disable iff (!rstN)
    hwStallSent |=> regRdData[B_SST]); // R7
  AST_FST_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (hwXferDone && !(regWrEn && regWrData[B_FST])) |=> !regRdData[B_FST]); // R8
  AST_SE_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRdData[B_SE]) |-> ($past(hwSetupEnd) && !$past(regRdData[B_DE]))); // R10
endmodule

bind ctlEpStatusReg ctlEpStatusReg_chk u_chk (.*);

// File: tb/ctlEpStatusReg_test.sv
module ctlEpStatusReg_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irqEnable = 1'b0, irqClr = 1'b0, epIrq;
  logic hwOutRcvd = 1'b0, hwInSent = 1'b0, hwStallSent = 1'b0;
  logic hwSetupEnd = 1'b0, hwXferDone = 1'b0;
  logic dataStageOk, stallReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural reference state
  bit mOut, mIn, mSst, mFst, mDe, mSe, mIrq;

  ctlEpStatusReg uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    bit [7:0] w;
    bit inFire, oldDe;
    cycles++;
    if (!rstN) begin
      {mOut, mIn, mSst, mFst, mDe, mSe, mIrq} = '0;
    end else begin
      w = regWrEn ? regWrData : 8'h00;
      oldDe = mDe;
      inFire = hwInSent && mIn;
      if (hwOutRcvd) mOut = 1; else if (w[6]) mOut = 0;
      if (inFire) mIn = 0; else if (w[1]) mIn = 1;
      if (hwStallSent) mSst = 1; else if (w[2]) mSst = 0;
      if (w[3]) mFst = 1; else if (hwStallSent || hwXferDone) mFst = 0;
      if (w[4]) mDe = 1; else if (hwXferDone) mDe = 0;
      if (hwSetupEnd && !oldDe) mSe = 1; else if (w[7]) mSe = 0;
      if (irqEnable && (hwOutRcvd || inFire)) mIrq = 1; else if (irqClr) mIrq = 0;
    end
  end

  task automatic chk(input logic act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cycles, act, exp);
    end
  endtask

  task automatic compareAll(input bit inReset);
    string p;
    p = inReset ? "R1 " : "";
    chk(regRdData[0], mOut, {p, "R2 out-ready"});
    chk(regRdData[1], mIn,  {p, "R4 in-ready"});
    chk(regRdData[2], mSst, {p, "R7 sent-stall"});
    chk(regRdData[3], mFst, {p, "R8 force-stall"});
    chk(regRdData[4], mDe,  {p, "R9 data-end"});
    chk(regRdData[5], mSe,  {p, "R10 setup-end"});
    chk(regRdData[6], 1'b0, "R11 bit6 reads 0");
    chk(regRdData[7], 1'b0, "R11 bit7 reads 0");
    chk(epIrq, mIrq, {p, "R5 R6 interrupt flag"});
    chk(dataStageOk, !mOut, {p, "R3 data-stage gate"});
    chk(stallReq, mFst, {p, "R8 stall request"});
  endtask

  // drive at falling edge after comparing the state from the last rising edge
  task automatic runPhase(input int n, input int pEv, input int pWr, input int pIrqEn);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll(1'b0);
      regWrEn     = ($urandom_range(99) < pWr);
      regWrData   = 8'($urandom);
      irqEnable   = ($urandom_range(99) < pIrqEn);
      irqClr      = ($urandom_range(99) < pEv);
      hwOutRcvd   = ($urandom_range(99) < pEv);
      hwInSent    = ($urandom_range(99) < pEv);
      hwStallSent = ($urandom_range(99) < pEv);
      hwSetupEnd  = ($urandom_range(99) < pEv);
      hwXferDone  = ($urandom_range(99) < pEv);
    end
  endtask

  task automatic idle();
    regWrEn = 0; regWrData = '0; irqClr = 0;
    hwOutRcvd = 0; hwInSent = 0; hwStallSent = 0; hwSetupEnd = 0; hwXferDone = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compareAll(1'b1);              // R1 reset state
    rstN = 1'b1;

    // directed: R9 set data-end while servicing OUT-ready in one write
    @(negedge clk); hwOutRcvd = 1; irqEnable = 1;
    @(negedge clk); compareAll(1'b0); idle();
    regWrEn = 1; regWrData = 8'h50;
    @(negedge clk); compareAll(1'b0); idle();
    // directed: R11 writing zeros and disabled writes change nothing
    regWrEn = 1; regWrData = 8'h00;
    @(negedge clk); compareAll(1'b0); idle();
    regWrData = 8'hFF;
    @(negedge clk); compareAll(1'b0); idle();
    // directed: R10 early end with data-end set is ignored
    hwSetupEnd = 1;
    @(negedge clk); compareAll(1'b0); idle();

    runPhase(4000, 30, 40, 70);   // dense collisions
    runPhase(4000, 8,  20, 50);   // sparse events
    runPhase(2000, 50, 60, 0);    // interrupts disabled, R5
    runPhase(2000, 15, 80, 100);
    @(negedge clk); compareAll(1'b0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired after %0d cycles", MAX_CYCLES);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule